// File: doc/BRIEF.md
# Fractional Conversion Pacing Divider

This block paces a stream of continuous conversions by issuing a one-cycle start tick at a programmable interval. The interval is measured in system clock cycles. The setting has two parts: a 16-bit whole part and an 8-bit fraction in 1/256 steps. The average spacing between ticks is one cycle, plus the whole part, plus the fraction divided by 256.

The fraction is realised by an 8-bit accumulator that dithers between two whole-cycle intervals. The accumulator adds the fraction once per interval, and an interval is one cycle longer whenever that addition carries.

A setting of zero in both parts turns pacing off. The block then emits no ticks and drops its pacing-active flag, so the downstream sequencer runs conversions back to back. Any write of the setting restarts the count and the accumulator. The sequencer that consumes the tick is not part of this block.

Top module: `pace_divider`

## Requirements
- R1: After reset the stored setting is zero, `tick` is low and `pacing_active` is low.
- R2: `pacing_active` is high exactly when the stored whole part or the stored fraction is non-zero. While it is low, `tick` never rises.
- R3: `tick` is produced only while `run_en` is high. While `run_en` is low, the counter and the accumulator are held cleared. Counting the first cycle with `run_en` high as cycle 0, the first tick falls in cycle equal to the whole part.
- R4: Each interval between ticks is either whole+1 or whole+2 cycles. It is whole+2 exactly when adding the fraction into the 8-bit accumulator carries out of bit 7. The accumulator starts at 0 and advances by the fraction on every tick.
- R5: Any 256 consecutive tick intervals together last exactly 256*(1+whole)+fraction cycles.
- R6: A cycle with `div_wr` high loads the whole part from `div_int_in` and the fraction from `div_frac_in`, and clears the counter and the accumulator. Counting the cycle after the write as cycle 0, the first tick falls in cycle equal to the new whole part.
- R7: In any cycle where `div_wr` is high, `tick` is low, even when a tick was due in that cycle.
- R8: `tick` is a single-cycle pulse: with a whole part of 1 or more, it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Continuous-conversion mode is on; enables pacing |
| div_wr | input | 1 | Write strobe for the pacing setting |
| div_int_in | input | 16 | Whole part of the interval, loaded on `div_wr` |
| div_frac_in | input | 8 | Fraction of the interval in 1/256 cycles, loaded on `div_wr` |
| tick | output | 1 | One-cycle start pulse for the next conversion |
| pacing_active | output | 1 | Stored setting is non-zero, so pacing is in force |

## Verification
Two functions can fall in the same cycle: a setting write and a tick that is due. The bench provokes this by loading a whole part of 3 and then issuing a write again in exactly the cycle where the tick is due. It judges the outcome at the ports. The tick must be absent in the write cycle, and the next tick must arrive a full whole+1 cycles later, counted from the write. The second overlap is between `run_en` falling and a pending count. The bench drops `run_en` part way through an interval, raises it again, and checks that the first tick comes a fresh whole+1 cycles after the rise.

// File: rtl/pace_pkg.sv
package pace_pkg;
   localparam int unsigned PACE_INT_W_DEF  = 16;
   localparam int unsigned PACE_FRAC_W_DEF = 8;

   // Cycles of one interval for a whole part and a carry flag.
   function automatic int unsigned pace_interval(input int unsigned whole, input bit carry);
      return whole + 1 + (carry ? 1 : 0);
   endfunction
endpackage

// File: rtl/pace_divreg.sv
module pace_divreg #(
   parameter int unsigned INT_W  = 16,
   parameter int unsigned FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [INT_W-1:0]  int_in,
   input  logic [FRAC_W-1:0] frac_in,
   output logic [INT_W-1:0]  int_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic              active
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q  <= '0;
         frac_q <= '0;
      end else if (wr) begin
         int_q  <= int_in;
         frac_q <= frac_in;
      end
   end

   assign active = (|int_q) | (|frac_q);

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (int_q == $past(int_in)) && (frac_q == $past(frac_in))) else $error("load"); // R6
   AST_HOLD_SETTING: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(int_q) && $stable(frac_q)) else $error("hold"); // R6
endmodule

// File: rtl/pace_frac_acc.sv
module pace_frac_acc #(
   parameter int unsigned FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [FRAC_W-1:0] frac,
   output logic              carry
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   // Look-ahead: the interval now running uses the carry of the next addition.
   assign sum   = {1'b0, acc_q} + {1'b0, frac};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q <= '0;
      else if (adv)      acc_q <= sum[FRAC_W-1:0];
   end

   AST_ACC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(acc_q)) else $error("acc moved"); // R4
   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0)) else $error("acc clr"); // R6
endmodule

// File: rtl/pace_counter.sv
module pace_counter #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             due
);
   logic [CNT_W-1:0] cnt_q;

   assign due = (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (due)      cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)) else $error("cnt not held"); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit) else $error("cnt past limit"); // R4
endmodule

// File: rtl/pace_divider.sv
module pace_divider #(
   parameter int unsigned INT_W  = pace_pkg::PACE_INT_W_DEF,
   parameter int unsigned FRAC_W = pace_pkg::PACE_FRAC_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              div_wr,
   input  logic [INT_W-1:0]  div_int_in,
   input  logic [FRAC_W-1:0] div_frac_in,
   output logic              tick,
   output logic              pacing_active
);
   localparam int unsigned CNT_W = INT_W + 1;

   generate
      if (INT_W < 1 || INT_W > 31) begin : g_bad_int
         $error("INT_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
         $error("FRAC_W out of range");
      end
   endgenerate

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic              active;
   logic              carry;
   logic              due;
   logic              clr;
   logic [CNT_W-1:0]  limit;

   pace_divreg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(div_wr), .int_in(div_int_in), .frac_in(div_frac_in),
      .int_q(int_q), .frac_q(frac_q), .active(active));

   // Restart on a write; hold cleared when not running or not pacing.
   assign clr   = div_wr | ~run_en | ~active;
   assign tick  = due & ~clr;
   assign limit = {1'b0, int_q} + {{INT_W{1'b0}}, carry};
   assign pacing_active = active;

   pace_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .adv(tick), .frac(frac_q), .carry(carry));

   pace_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .limit(limit), .due(due));

   AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !pacing_active |-> !tick) else $error("tick while idle"); // R2
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |-> !tick) else $error("tick on write"); // R7
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (int_q != '0)) |=> !tick) else $error("wide tick"); // R8
endmodule

// File: tb/pace_divider_test.sv
module pace_divider_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {whole[15:0], fraction[7:0]}
   localparam logic [23:0] VEC [NVEC] = '{
      {16'd0, 8'd1}, {16'd0, 8'd128}, {16'd0, 8'd255}, {16'd1, 8'd0},
      {16'd2, 8'd64}, {16'd3, 8'd85}, {16'd5, 8'd200}, {16'd10, 8'd3}};

   logic        clk = 0;
   logic        rst_n = 0;
   logic        run_en = 0;
   logic        div_wr = 0;
   logic [15:0] div_int_in = 0;
   logic [7:0]  div_frac_in = 0;
   logic        tick;
   logic        pacing_active;

   int checks = 0;
   int errors = 0;

   pace_divider uut (.clk(clk), .rst_n(rst_n), .run_en(run_en), .div_wr(div_wr),
      .div_int_in(div_int_in), .div_frac_in(div_frac_in), .tick(tick),
      .pacing_active(pacing_active));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive one cycle's inputs after the falling edge, then sample tick in that cycle.
   task automatic step(input logic wr, input logic [15:0] ip, input logic [7:0] fp,
                       input logic run, output logic t);
      @(negedge clk);
      div_wr = wr; div_int_in = ip; div_frac_in = fp; run_en = run;
      #1;
      t = tick;
   endtask

   // Cycles until the first tick, counting the next cycle as 0.
   task automatic first_tick(input logic [15:0] ip, input logic [7:0] fp, output int at);
      logic t;
      at = -1;
      for (int c = 0; c < 70000 && at < 0; c++) begin
         step(1'b0, ip, fp, 1'b1, t);
         if (t) at = c;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic t;
      int   at;
      repeat (3) @(negedge clk);
      run_en = 1;
      #1;
      chk(tick == 0, "R1 tick after reset", tick, 0);
      chk(pacing_active == 0, "R1 pacing_active after reset", pacing_active, 0);
      @(negedge clk);
      rst_n = 1;

      // Table walk: first tick, every interval, and 256-interval total.
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] ip;
         logic [7:0]  fp;
         int first, prev, cnt, bad_iv, total, acc, exp_iv;
         ip = VEC[v][23:8];
         fp = VEC[v][7:0];
         step(1'b1, ip, fp, 1'b1, t);
         chk(t == 0, "R7 no tick in write cycle", t, 0);
         first = -1; prev = -1; cnt = 0; bad_iv = 0; total = 0; acc = 0;
         for (int c = 0; c < 256 * (int'(ip) + 3) + 10 && cnt < 257; c++) begin
            step(1'b0, ip, fp, 1'b1, t);
            if (t) begin
               cnt++;
               exp_iv = int'(ip) + 1 + ((acc + int'(fp) >= 256) ? 1 : 0);
               acc = (acc + int'(fp)) % 256;
               if (cnt == 1) begin
                  first = c;
                  chk(c == int'(ip), "R6 first tick after write", c, int'(ip));
               end else if (c - prev != exp_iv && bad_iv == 0) begin
                  bad_iv = 1;
                  chk(0, "R4 dithered interval", c - prev, exp_iv);
               end
               if (cnt == 257) total = c - first;
               prev = c;
            end
         end
         if (bad_iv == 0) chk(1, "R4 dithered interval", 0, 0);
         chk(total == 256 * (1 + int'(ip)) + int'(fp), "R5 total over 256 intervals",
             total, 256 * (1 + int'(ip)) + int'(fp));
         chk(pacing_active == 1, "R2 active with non-zero setting", pacing_active, 1);
      end

      // R2: zero setting gives no ticks and inactive flag.
      begin
         int seen = 0;
         step(1'b1, 16'd0, 8'd0, 1'b1, t);
         for (int c = 0; c < 40; c++) begin
            step(1'b0, 16'd0, 8'd0, 1'b1, t);
            if (t) seen++;
         end
         chk(seen == 0, "R2 no ticks with zero setting", seen, 0);
         chk(pacing_active == 0, "R2 inactive with zero setting", pacing_active, 0);
      end

      // R3: run_en low blocks ticks and clears a partial count.
      begin
         int seen = 0;
         step(1'b1, 16'd4, 8'd0, 1'b1, t);
         step(1'b0, 16'd4, 8'd0, 1'b1, t);
         step(1'b0, 16'd4, 8'd0, 1'b1, t);
         for (int c = 0; c < 20; c++) begin
            step(1'b0, 16'd4, 8'd0, 1'b0, t);
            if (t) seen++;
         end
         chk(seen == 0, "R3 no ticks with run_en low", seen, 0);
         first_tick(16'd4, 8'd0, at);
         chk(at == 4, "R3 first tick after run_en rises", at, 4);
      end

      // R7: a write in the tick-due cycle suppresses it and restarts.
      begin
         step(1'b1, 16'd3, 8'd0, 1'b1, t);
         for (int c = 0; c < 3; c++) step(1'b0, 16'd3, 8'd0, 1'b1, t);
         step(1'b1, 16'd3, 8'd0, 1'b1, t);
         chk(t == 0, "R7 due tick suppressed by write", t, 0);
         first_tick(16'd3, 8'd0, at);
         chk(at == 3, "R6 restart after colliding write", at, 3);
      end

      // R6: a write part way through an interval restarts the count.
      begin
         step(1'b1, 16'd9, 8'd0, 1'b1, t);
         for (int c = 0; c < 5; c++) step(1'b0, 16'd9, 8'd0, 1'b1, t);
         step(1'b1, 16'd6, 8'd0, 1'b1, t);
         first_tick(16'd6, 8'd0, at);
         chk(at == 6, "R6 mid-interval write restarts", at, 6);
      end

      // R8: whole part 1 gives isolated pulses.
      begin
         logic last = 0;
         int doubles = 0;
         step(1'b1, 16'd1, 8'd77, 1'b1, t);
         for (int c = 0; c < 60; c++) begin
            step(1'b0, 16'd1, 8'd77, 1'b1, t);
            if (t && last) doubles++;
            last = t;
         end
         chk(doubles == 0, "R8 single-cycle pulse", doubles, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule